// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen architectural general registers of a 32-bit RISC core that runs in several processor modes. A 5-bit mode code picks which physical copy a register index reaches. The fast-interrupt mode has private copies of the upper general registers 8 to 14. The other four exception modes each have private copies of only the stack pointer (register 13) and the link register (register 14). The two unprivileged-style modes, user and system, share one unbanked set. Register 15, the program counter, is one physical register that every mode sees.

The file has two combinational read ports and one write port that writes on the clock edge. It also holds one saved-status word for each of the five exception modes. The same mode code selects which saved-status word is read or written. Access to a saved-status word from user or system mode raises an invalid-access flag. An unknown mode code raises an error output, suppresses every write and forces the read data to zero. The instruction decoder is expected to drive the mode and index inputs directly each cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register copy, in every valid mode, and every saved-status word reads as zero.
- R2: The accepted mode codes are 5'b10000 (user), 5'b10001 (fast interrupt), 5'b10010 (interrupt), 5'b10011 (supervisor), 5'b10111 (abort), 5'b11011 (undefined) and 5'b11111 (system). Any other code drives `mode_err` high in the same cycle, and both read ports and `sps_rd_data` return zero.
- R3: A register or saved-status write presented while `mode_err` is high changes no stored value.
- R4: User and system modes reach the same storage for registers 0 to 14.
- R5: Fast-interrupt mode has private copies of registers 8 to 14 and shares registers 0 to 7 with user mode.
- R6: Interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14 and share registers 0 to 12 with user mode.
- R7: Register 15 is a single register shared by every valid mode.
- R8: A write lands only in the copy selected by the mode of its own cycle and is visible from the next cycle on. A read in the same cycle as a write to the same register returns the old value.
- R9: Each of the five exception modes owns one saved-status word, reached through `sps_wr_en`/`sps_wr_data` and `sps_rd_data` while that mode is applied.
- R10: In user or system mode, asserting `sps_rd_en` or `sps_wr_en` drives `sps_bad` high in that cycle. The write is dropped and `sps_rd_data` reads zero.
- R11: The two read ports are independent and may address any two registers, including the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_b_idx | input | 4 | Read port B register index |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sps_rd_en | input | 1 | Saved-status read request |
| sps_wr_en | input | 1 | Saved-status write enable |
| sps_wr_data | input | 32 | Saved-status write data |
| sps_rd_data | output | 32 | Saved-status word of the current mode |
| sps_bad | output | 1 | Saved-status access attempted in user or system mode |
| mode_err | output | 1 | Mode code is not one of the accepted codes |

## Verification
The read data, `mode_err` and `sps_bad` are pure functions of the present inputs and the stored state, so they are due in the same cycle. The bench drives inputs just after a falling edge and samples these outputs 1 ns later, before the next rising edge. At that point a write offered in the same cycle has not yet landed, which is how the old-value rule is checked. A write takes effect at the next rising edge, so the bench updates its per-mode reference arrays only after that edge and compares reads from the following cycle on. A closing sweep reads all sixteen indices in each of the seven modes.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } cpu_mode_e;

   localparam int MODE_W      = 5;
   localparam int ARCH_REGS   = 16;
   localparam int IDX_W       = $clog2(ARCH_REGS);
   // fast-interrupt private range starts at this architectural index
   localparam int FIQ_LO      = 8;
   // small-bank private range (stack pointer and link register)
   localparam int SMALL_LO    = 13;
   localparam int PC_IDX      = 15;
   localparam int SMALL_MODES = 4;
   localparam int SPS_COUNT   = 5;

   localparam int FIQ_BANK_N   = PC_IDX - FIQ_LO;
   localparam int SMALL_BANK_N = PC_IDX - SMALL_LO;
   localparam int FIQ_BASE     = ARCH_REGS;
   localparam int SMALL_BASE   = FIQ_BASE + FIQ_BANK_N;
   localparam int PHYS_REGS    = SMALL_BASE + SMALL_MODES * SMALL_BANK_N;
   localparam int PHYS_W       = $clog2(PHYS_REGS);
   localparam int SPS_W        = $clog2(SPS_COUNT);

endpackage

// File: rtl/bankrf_mode_decode.sv
module bankrf_mode_decode
   import bankrf_pkg::*;
(
   input  logic [MODE_W-1:0]                 mode_i,
   output logic                              mode_ok,
   output logic                              is_fiq,
   output logic                              is_small,
   output logic [$clog2(SMALL_MODES)-1:0]    small_slot,
   output logic                              sps_ok,
   output logic [SPS_W-1:0]                  sps_slot
);

   always_comb begin
      mode_ok    = 1'b1;
      is_fiq     = 1'b0;
      is_small   = 1'b0;
      small_slot = '0;
      sps_ok     = 1'b1;
      sps_slot   = '0;
      case (mode_i)
         MODE_USR, MODE_SYS: sps_ok = 1'b0;
         MODE_FIQ: begin
            is_fiq   = 1'b1;
            sps_slot = SPS_W'(0);
         end
         MODE_IRQ: begin
            is_small   = 1'b1;
            small_slot = 2'd0;
            sps_slot   = SPS_W'(1);
         end
         MODE_SVC: begin
            is_small   = 1'b1;
            small_slot = 2'd1;
            sps_slot   = SPS_W'(2);
         end
         MODE_ABT: begin
            is_small   = 1'b1;
            small_slot = 2'd2;
            sps_slot   = SPS_W'(3);
         end
         MODE_UND: begin
            is_small   = 1'b1;
            small_slot = 2'd3;
            sps_slot   = SPS_W'(4);
         end
         default: begin
            mode_ok = 1'b0;
            sps_ok  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/bankrf_index_map.sv
module bankrf_index_map
   import bankrf_pkg::*;
(
   input  logic [IDX_W-1:0]               arch_idx,
   input  logic                           is_fiq,
   input  logic                           is_small,
   input  logic [$clog2(SMALL_MODES)-1:0] small_slot,
   output logic [PHYS_W-1:0]              phys_idx
);

   logic [PHYS_W-1:0] arch_ext;
   logic [PHYS_W-1:0] fiq_off;
   logic [PHYS_W-1:0] small_off;

   always_comb begin
      arch_ext  = PHYS_W'(arch_idx);
      fiq_off   = arch_ext - PHYS_W'(FIQ_LO);
      small_off = PHYS_W'(small_slot) * PHYS_W'(SMALL_BANK_N)
                  + (arch_ext - PHYS_W'(SMALL_LO));
      if (arch_ext == PHYS_W'(PC_IDX) || arch_ext < PHYS_W'(FIQ_LO))
         phys_idx = arch_ext;
      else if (is_fiq)
         phys_idx = PHYS_W'(FIQ_BASE) + fiq_off;
      else if (is_small && arch_ext >= PHYS_W'(SMALL_LO))
         phys_idx = PHYS_W'(SMALL_BASE) + small_off;
      else
         phys_idx = arch_ext;
   end

endmodule

// File: rtl/bankrf_storage.sv
module bankrf_storage #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 31,
   parameter bit RESET_CLEARS = 1'b1,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     w_idx,
   input  logic [DATA_W-1:0] w_data,
   input  logic [AW-1:0]     ra_idx,
   input  logic [AW-1:0]     rb_idx,
   output logic [DATA_W-1:0] ra_data,
   output logic [DATA_W-1:0] rb_data
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bankrf_storage: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (RESET_CLEARS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cells[i] <= '0;
            else if (we && w_idx == AW'(i))
               cells[i] <= w_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && w_idx == AW'(i))
               cells[i] <= w_data;
         end
      end
   end

   always_comb begin
      ra_data = '0;
      rb_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (ra_idx == AW'(k)) ra_data = cells[k];
         if (rb_idx == AW'(k)) rb_data = cells[k];
      end
   end

endmodule

// File: rtl/bankrf_status_bank.sv
module bankrf_status_bank #(
   parameter int DATA_W = 32,
   parameter int COUNT  = 5,
   localparam int SW    = $clog2(COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SW-1:0]     slot,
   input  logic [DATA_W-1:0] w_data,
   output logic [DATA_W-1:0] r_data
);

   logic [DATA_W-1:0] words [COUNT];

   for (genvar i = 0; i < COUNT; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[i] <= '0;
         else if (we && slot == SW'(i))
            words[i] <= w_data;
      end
   end

   always_comb begin
      r_data = '0;
      for (int k = 0; k < COUNT; k++)
         if (slot == SW'(k)) r_data = words[k];
   end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bankrf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit RESET_CLEARS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MODE_W-1:0]     mode_i,
   input  logic [IDX_W-1:0]      rd_a_idx,
   input  logic [IDX_W-1:0]      rd_b_idx,
   output logic [DATA_W-1:0]     rd_a_data,
   output logic [DATA_W-1:0]     rd_b_data,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  sps_rd_en,
   input  logic                  sps_wr_en,
   input  logic [DATA_W-1:0]     sps_wr_data,
   output logic [DATA_W-1:0]     sps_rd_data,
   output logic                  sps_bad,
   output logic                  mode_err
);

   if (DATA_W < 8) begin : g_bad_width
      $error("banked_regfile: DATA_W must be at least 8");
   end
   if (PHYS_REGS > (1 << PHYS_W)) begin : g_bad_phys
      $error("banked_regfile: physical index too narrow");
   end

   localparam int NPORT = 3;  // port 0 write, 1 read A, 2 read B

   logic                           mode_ok, is_fiq, is_small, sps_ok;
   logic [$clog2(SMALL_MODES)-1:0] small_slot;
   logic [SPS_W-1:0]               sps_slot;
   logic [IDX_W-1:0]               arch_idx [NPORT];
   logic [PHYS_W-1:0]              phys_idx [NPORT];
   logic [DATA_W-1:0]              raw_a, raw_b, raw_sps;

   bankrf_mode_decode u_dec (
      .mode_i     (mode_i),
      .mode_ok    (mode_ok),
      .is_fiq     (is_fiq),
      .is_small   (is_small),
      .small_slot (small_slot),
      .sps_ok     (sps_ok),
      .sps_slot   (sps_slot)
   );

   assign arch_idx[0] = wr_idx;
   assign arch_idx[1] = rd_a_idx;
   assign arch_idx[2] = rd_b_idx;

   for (genvar p = 0; p < NPORT; p++) begin : g_map
      bankrf_index_map u_map (
         .arch_idx   (arch_idx[p]),
         .is_fiq     (is_fiq),
         .is_small   (is_small),
         .small_slot (small_slot),
         .phys_idx   (phys_idx[p])
      );
   end

   bankrf_storage #(
      .DATA_W       (DATA_W),
      .DEPTH        (PHYS_REGS),
      .RESET_CLEARS (RESET_CLEARS)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en & mode_ok),
      .w_idx   (phys_idx[0]),
      .w_data  (wr_data),
      .ra_idx  (phys_idx[1]),
      .rb_idx  (phys_idx[2]),
      .ra_data (raw_a),
      .rb_data (raw_b)
   );

   bankrf_status_bank #(
      .DATA_W (DATA_W),
      .COUNT  (SPS_COUNT)
   ) u_sps (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (sps_wr_en & sps_ok),
      .slot   (sps_slot),
      .w_data (sps_wr_data),
      .r_data (raw_sps)
   );

   assign mode_err    = ~mode_ok;
   assign rd_a_data   = mode_ok ? raw_a : '0;
   assign rd_b_data   = mode_ok ? raw_b : '0;
   assign sps_rd_data = sps_ok ? raw_sps : '0;
   assign sps_bad     = (sps_rd_en | sps_wr_en) & mode_ok & ~sps_ok;

endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker
   import bankrf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [MODE_W-1:0]     mode_i,
   input logic [IDX_W-1:0]      rd_a_idx,
   input logic [IDX_W-1:0]      rd_b_idx,
   input logic [DATA_W-1:0]     rd_a_data,
   input logic [DATA_W-1:0]     rd_b_data,
   input logic                  wr_en,
   input logic [IDX_W-1:0]      wr_idx,
   input logic [DATA_W-1:0]     wr_data,
   input logic                  sps_rd_en,
   input logic                  sps_wr_en,
   input logic [DATA_W-1:0]     sps_wr_data,
   input logic [DATA_W-1:0]     sps_rd_data,
   input logic                  sps_bad,
   input logic                  mode_err
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_bad_mode_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (rd_a_data == '0 && rd_b_data == '0 && sps_rd_data == '0));

   assert_bad_mode_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && $past(!mode_err, 2) && !$past(wr_en, 2)
       && $past(mode_err && wr_en) && !mode_err
       && mode_i == $past(mode_i, 2) && rd_a_idx == $past(rd_a_idx, 2))
      |-> rd_a_data == $past(rd_a_data, 2));

   assert_pc_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(wr_en && !mode_err && wr_idx == 4'd15)
       && !mode_err && rd_b_idx == 4'd15)
      |-> rd_b_data == $past(wr_data));

   assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(wr_en && !mode_err) && mode_i == $past(mode_i)
       && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

   assert_sps_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(sps_wr_en && !sps_bad && !mode_err)
       && mode_i == $past(mode_i))
      |-> sps_rd_data == $past(sps_wr_data));

   assert_sps_bad_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((sps_rd_en || sps_wr_en) && (mode_i == 5'b10000 || mode_i == 5'b11111))
      |-> (sps_bad && sps_rd_data == '0));

endmodule

bind banked_regfile bankrf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mode_i = 5'b10000;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0, sps_rd_en = 1'b0, sps_wr_en = 1'b0;
   logic [31:0] sps_wr_data = '0, sps_rd_data;
   logic        sps_bad, mode_err;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [31:0] ref_r   [7][16];
   logic [31:0] ref_sps [7];

   localparam logic [4:0] CODES [7] = '{5'b10000, 5'b10001, 5'b10010,
                                        5'b10011, 5'b10111, 5'b11011, 5'b11111};
   localparam logic [4:0] BADS  [4] = '{5'b00000, 5'b10100, 5'b11110, 5'b01111};

   banked_regfile u_banked_regfile (
      .clk, .rst_n, .mode_i, .rd_a_idx, .rd_b_idx, .rd_a_data, .rd_b_data,
      .wr_en, .wr_idx, .wr_data, .sps_rd_en, .sps_wr_en, .sps_wr_data,
      .sps_rd_data, .sps_bad, .mode_err
   );

   always #4 clk = ~clk;

   function automatic int midx(input logic [4:0] c);
      for (int i = 0; i < 7; i++) if (CODES[i] == c) return i;
      return -1;
   endfunction

   // storage group of register r in mode index m (R4..R7)
   function automatic int grp(input int m, input int r);
      if (r == 15 || r < 8) return 0;
      if (m == 1) return 1;
      if (m >= 2 && m <= 5 && r >= 13) return m;
      return 0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input string tag, input logic [4:0] m, input logic we,
                       input logic [3:0] wi, input logic [31:0] wd,
                       input logic [3:0] ra, input logic [3:0] rb,
                       input logic sre, input logic swe, input logic [31:0] swd);
      int mi;
      logic usr;
      mi = midx(m);
      usr = (mi == 0 || mi == 6);
      mode_i = m; wr_en = we; wr_idx = wi; wr_data = wd;
      rd_a_idx = ra; rd_b_idx = rb; sps_rd_en = sre; sps_wr_en = swe; sps_wr_data = swd;
      #1;
      chk({tag, " mode_err R2"}, {31'b0, mode_err}, {31'b0, mi < 0});
      chk({tag, " port A R8/R11"}, rd_a_data, mi < 0 ? 32'h0 : ref_r[mi][ra]);
      chk({tag, " port B R11"}, rd_b_data, mi < 0 ? 32'h0 : ref_r[mi][rb]);
      chk({tag, " sps data R9/R10"}, sps_rd_data, (mi < 0 || usr) ? 32'h0 : ref_sps[mi]);
      chk({tag, " sps_bad R10"}, {31'b0, sps_bad}, {31'b0, (sre | swe) & (mi >= 0) & usr});
      @(posedge clk);
      if (mi >= 0 && we)
         for (int k = 0; k < 7; k++)
            if (grp(k, wi) == grp(mi, wi)) ref_r[k][wi] = wd;
      if (mi >= 0 && !usr && swe) ref_sps[mi] = swd;
      @(negedge clk);
      wr_en = 1'b0; sps_wr_en = 1'b0; sps_rd_en = 1'b0;
   endtask

   task automatic sweep(input string tag);
      for (int m = 0; m < 7; m++)
         for (int r = 0; r < 16; r += 2)
            step(tag, CODES[m], 1'b0, 4'd0, 32'h0, 4'(r), 4'(r + 1), 1'b1, 1'b0, 32'h0);
   endtask

   initial begin
      for (int m = 0; m < 7; m++) begin
         ref_sps[m] = '0;
         for (int r = 0; r < 16; r++) ref_r[m][r] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1 reset");

      // R4: user writes r12, seen in system
      step("R4 wr", 5'b10000, 1'b1, 4'd12, 32'hA5A5_0012, 4'd0, 4'd0, 1'b0, 1'b0, 32'h0);
      step("R4 rd", 5'b11111, 1'b0, 4'd0, 32'h0, 4'd12, 4'd12, 1'b0, 1'b0, 32'h0);
      // R5: fiq private r8, shared r7
      step("R5 wr", 5'b10001, 1'b1, 4'd8, 32'hF1F1_0008, 4'd8, 4'd7, 1'b0, 1'b0, 32'h0);
      step("R5 wr7", 5'b10001, 1'b1, 4'd7, 32'hF1F1_0007, 4'd8, 4'd7, 1'b0, 1'b0, 32'h0);
      step("R5 rd", 5'b10000, 1'b0, 4'd0, 32'h0, 4'd8, 4'd7, 1'b0, 1'b0, 32'h0);
      // R6: supervisor private r13, shared r12
      step("R6 wr", 5'b10011, 1'b1, 4'd13, 32'h5C5C_0013, 4'd13, 4'd12, 1'b0, 1'b0, 32'h0);
      step("R6 rd", 5'b10010, 1'b0, 4'd0, 32'h0, 4'd13, 4'd12, 1'b0, 1'b0, 32'h0);
      // R7: pc written in undefined mode, read in fiq
      step("R7 wr", 5'b11011, 1'b1, 4'd15, 32'h0000_8000, 4'd15, 4'd15, 1'b0, 1'b0, 32'h0);
      step("R7 rd", 5'b10001, 1'b0, 4'd0, 32'h0, 4'd15, 4'd14, 1'b0, 1'b0, 32'h0);
      // R8: same-cycle read of the register being written returns old value
      step("R8 same", 5'b10111, 1'b1, 4'd14, 32'hAB00_0014, 4'd14, 4'd14, 1'b0, 1'b0, 32'h0);
      step("R8 next", 5'b10111, 1'b0, 4'd0, 32'h0, 4'd14, 4'd13, 1'b0, 1'b0, 32'h0);
      // R3: invalid-mode writes dropped
      for (int b = 0; b < 4; b++)
         step("R3 wr", BADS[b], 1'b1, 4'(b + 4), 32'hDEAD_0000 + b, 4'(b + 4), 4'd15, 1'b0, 1'b1, 32'hBAD0_0000);
      step("R3 rd", 5'b10000, 1'b0, 4'd0, 32'h0, 4'd4, 4'd5, 1'b0, 1'b0, 32'h0);
      step("R3 rd2", 5'b10000, 1'b0, 4'd0, 32'h0, 4'd6, 4'd7, 1'b0, 1'b0, 32'h0);
      // R9: saved-status per exception mode
      for (int m = 1; m <= 5; m++)
         step("R9 wr", CODES[m], 1'b0, 4'd0, 32'h0, 4'd0, 4'd0, 1'b1, 1'b1, 32'h5000_0000 + m);
      for (int m = 1; m <= 5; m++)
         step("R9 rd", CODES[m], 1'b0, 4'd0, 32'h0, 4'd0, 4'd0, 1'b1, 1'b0, 32'h0);
      // R10: user/system saved-status access flagged, write dropped
      step("R10 usr", 5'b10000, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0, 1'b0, 1'b1, 32'h1111_1111);
      step("R10 sys", 5'b11111, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0, 1'b1, 1'b1, 32'h2222_2222);
      step("R10 after", 5'b10010, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0, 1'b1, 1'b0, 32'h0);

      // random writes interleaved with mode changes
      for (int it = 0; it < 3000; it++) begin
         logic [4:0] m;
         int pick;
         pick = int'($urandom_range(0, 8));
         m = (pick < 7) ? CODES[pick] : BADS[$urandom_range(0, 3)];
         step("rand", m, 1'($urandom), 4'($urandom), $urandom, 4'($urandom), 4'($urandom),
              1'($urandom), 1'($urandom), $urandom);
      end
      sweep("R4/R5/R6/R7 final");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule